// File: doc/BRIEF.md
# Half-Duplex Converter Bus Controller

This controller sits on the host side of a converter that pairs a 7-bit transmit DAC with a 5-bit receive ADC. Both converters share one parallel data bus. The host asks for transmit, receive or shutdown on a two-bit request. The controller then drives the converter's two enable lines and generates the converter clock by dividing the system clock. In transmit it drives queued 7-bit two's-complement samples onto all seven bus pins. In receive it releases the low five pins and captures 5-bit two's-complement samples, which it presents as a one-cycle valid/data stream.

Every entry into an active mode waits out a wake-up hold-off before the controller offers or accepts data. This applies when leaving shutdown and also on a direct change between transmit and receive. The hold-off is a cycle count derived from the system clock rate, and `ready` rises when it expires. Bus turnaround is sequenced so that the host and the converter never drive the low pins at the same time. While shut down, the controller drives the low pins to zero.

Top module: `cvbus_ctrl`

## Requirements
- R1: `mode_req` selects the mode: 2'b01 is transmit (`cv_txen`=1, `cv_rxen`=0), 2'b10 is receive (`cv_rxen`=1, `cv_txen`=0), and 2'b00 or 2'b11 is shutdown (both enables 0). The two enables are never high together.
- R2: `cv_clk` toggles every `CLK_HALF` system cycles, giving a period of 2*`CLK_HALF` cycles (8 by default). It runs in every mode, shutdown included.
- R3: `ready` rises exactly WAKE_CYC system cycles after the target enable goes high. WAKE_CYC is the wake time rounded up to whole cycles, which is 240 by default. Before that, `tx_ready` and `rx_valid` stay low.
- R4: In active transmit, accepted samples appear on `bus_out[6:0]` in acceptance order, bit 6 being the MSB, with their values unchanged (for example 7'h3F and 7'h40). While transmit stays enabled, `bus_out` changes only in the cycle in which `cv_clk` rises, so it is stable across every falling edge.
- R5: When no sample is pending at a rising `cv_clk` edge in active transmit, `bus_out` is driven to 7'h00, the mid-scale code.
- R6: In active receive, `bus_in[4:0]` (bit 4 being the MSB) is captured at each falling `cv_clk` edge. It appears on `rx_data` with `rx_valid` high for one cycle.
- R7: The first falling edge after `ready` rises in receive produces no `rx_valid`. Every later falling edge produces one.
- R8: `bus_oe_lo` is low for at least one cycle before `cv_rxen` rises and stays low while `cv_rxen` is high. `bus_oe_lo` goes high in transmit only after `cv_txen` has been high for a cycle.
- R9: In shutdown, `bus_oe_lo` is 1, `bus_out` is 0 and `ready` is 0.
- R10: Any change of the decoded request drops `ready`, discards a pending transmit sample so that it never reaches the bus, and restarts the full hold-off, even when the change arrives during an unfinished hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req | input | 2 | Requested mode: 01 transmit, 10 receive, 00/11 shutdown |
| tx_valid | input | 1 | Transmit sample offered |
| tx_data | input | 7 | Transmit sample, two's complement |
| tx_ready | output | 1 | Transmit sample accepted this cycle when tx_valid is high |
| rx_valid | output | 1 | One-cycle strobe for a received sample |
| rx_data | output | 5 | Received sample, two's complement |
| ready | output | 1 | Hold-off expired, mode active |
| cv_clk | output | 1 | Converter clock |
| cv_txen | output | 1 | Converter transmit enable |
| cv_rxen | output | 1 | Converter receive enable |
| bus_out | output | 7 | Host drive value for bus pins 6..0 |
| bus_oe_lo | output | 1 | Host output enable for bus pins 4..0 (pins 6..5 are always host-driven) |
| bus_in | input | 5 | Bus pins 4..0 as read by the host |

## Verification
A stuck or mis-sequenced mode state shows up on the enable pins two cycles after a request changes, and on `ready` exactly 240 cycles later. An off-by-one in the hold-off counter therefore shows as a wrong cycle distance, not as a functional failure. A lost or stale pending flag shows within one converter clock period: a sample is missing, duplicated, or carries a flushed value onto `bus_out` at the next rising edge. A wrong discard flag shows as an extra or a missing `rx_valid` on the first falling edge after `ready`. An output enable that is sequenced wrongly breaks the one-cycle gap around the rise of `cv_rxen` or `cv_txen`.

// File: rtl/cvbus_ctrl.sv
module cvbus_ctrl #(
  parameter int SYS_CLK_KHZ = 100000,
  parameter int WAKE_NS     = 2400,
  parameter int CLK_HALF    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       tx_valid,
  input  logic [6:0] tx_data,
  output logic       tx_ready,
  output logic       rx_valid,
  output logic [4:0] rx_data,
  output logic       ready,
  output logic       cv_clk,
  output logic       cv_txen,
  output logic       cv_rxen,
  output logic [6:0] bus_out,
  output logic       bus_oe_lo,
  input  logic [4:0] bus_in
);

  localparam longint WAKE_PROD = longint'(WAKE_NS) * longint'(SYS_CLK_KHZ);
  localparam int WAKE_RAW = int'((WAKE_PROD + 64'd999999) / 64'd1000000);
  localparam int WAKE_CYC = (WAKE_RAW < 1) ? 1 : WAKE_RAW;
  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam int DW = $clog2(CLK_HALF + 1);
  localparam logic [1:0] MD_SHUT = 2'b00;
  localparam logic [1:0] MD_TX   = 2'b01;
  localparam logic [1:0] MD_RX   = 2'b10;

  typedef enum logic [1:0] {S_SHUT, S_TURN, S_WAKE, S_ACT} state_t;

  state_t        state;
  logic [1:0]    tgt;
  logic [1:0]    want;
  logic [WW-1:0] wcnt;
  logic [DW-1:0] div;
  logic          pend;
  logic [6:0]    pdata;
  logic          first;
  logic          rise_evt, fall_evt, on;

  assign want     = (mode_req == 2'b11) ? MD_SHUT : mode_req;
  assign on       = (state == S_WAKE) || (state == S_ACT);
  assign cv_txen  = on && (tgt == MD_TX);
  assign cv_rxen  = on && (tgt == MD_RX);
  assign ready    = (state == S_ACT);
  assign tx_ready = ready && (tgt == MD_TX) && !pend;
  assign rise_evt = (div == DW'(CLK_HALF - 1)) && !cv_clk;
  assign fall_evt = (div == DW'(CLK_HALF - 1)) && cv_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div    <= '0;
      cv_clk <= 1'b0;
    end else if (div == DW'(CLK_HALF - 1)) begin
      div    <= '0;
      cv_clk <= ~cv_clk;
    end else begin
      div <= div + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_SHUT;
      tgt       <= MD_SHUT;
      wcnt      <= '0;
      bus_oe_lo <= 1'b1;
      bus_out   <= '0;
      pend      <= 1'b0;
      pdata     <= '0;
      first     <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (want != tgt) begin
        tgt       <= want;
        state     <= S_TURN;
        bus_oe_lo <= 1'b0;
        bus_out   <= '0;
        pend      <= 1'b0;
        wcnt      <= '0;
      end else begin
        case (state)
          S_TURN: begin
            if (tgt == MD_SHUT) begin
              state     <= S_SHUT;
              bus_oe_lo <= 1'b1;
            end else begin
              state <= S_WAKE;
              wcnt  <= '0;
            end
          end
          S_SHUT: begin
            bus_oe_lo <= 1'b1;
            bus_out   <= '0;
          end
          S_WAKE: begin
            if (cv_txen) bus_oe_lo <= 1'b1;
            if (wcnt == WW'(WAKE_CYC - 1)) begin
              state <= S_ACT;
              first <= 1'b1;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
          S_ACT: begin
            if (tgt == MD_TX) begin
              if (rise_evt) begin
                bus_out <= pend ? pdata : 7'd0;
                if (pend) pend <= 1'b0;
              end
              if (tx_valid && tx_ready) begin
                pend  <= 1'b1;
                pdata <= tx_data;
              end
            end else if (fall_evt) begin
              if (first) first <= 1'b0;
              else begin
                rx_valid <= 1'b1;
                rx_data  <= bus_in;
              end
            end
          end
          default: state <= S_SHUT;
        endcase
      end
    end
  end

  AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cv_txen && cv_rxen)); // R1
  AST_RX_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    cv_rxen |-> !bus_oe_lo); // R8
  AST_RX_GAP_BEFORE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cv_rxen) |-> $past(!bus_oe_lo)); // R8
  AST_TX_DRIVE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe_lo && cv_txen) |-> $past(cv_txen)); // R8
  AST_TX_BUS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_txen && $past(cv_txen) && !$stable(bus_out)) |-> $rose(cv_clk)); // R4
  AST_NO_RX_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (ready && cv_rxen)); // R3
  AST_NO_TX_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (ready && cv_txen)); // R3
  AST_SHUT_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cv_txen && !cv_rxen && bus_oe_lo) |-> (bus_out == 7'd0 && !ready)); // R9

endmodule

// File: tb/tb_cvbus_ctrl.sv
module tb_cvbus_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_req = 2'b00;
  logic       tx_valid = 1'b0;
  logic [6:0] tx_data = '0;
  logic       tx_ready, rx_valid, ready, cv_clk, cv_txen, cv_rxen, bus_oe_lo;
  logic [4:0] rx_data;
  logic [6:0] bus_out;
  logic [4:0] bus_in = '0;

  int errors = 0;
  int checks = 0;
  int viol4 = 0, viol8 = 0, viol3 = 0;
  int seen_flushed = 0;
  logic [6:0] got [0:63];
  int ngot = 0;
  logic p_cv = 0, p_txen = 0, p_rxen = 0, p_oe = 1, p_mon = 0;
  logic [6:0] p_bus = '0;

  localparam int WAKE = 240;

  cvbus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .ready(ready), .cv_clk(cv_clk), .cv_txen(cv_txen),
    .cv_rxen(cv_rxen), .bus_out(bus_out), .bus_oe_lo(bus_oe_lo), .bus_in(bus_in)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge cv_clk);
      #5 bus_in = bus_in + 5'd1;
    end
  end

  initial begin
    forever begin
      @(negedge cv_clk);
      if (cv_txen && !cv_rxen && ready && bus_oe_lo && bus_out != 7'd0 && ngot < 64) begin
        got[ngot] = bus_out;
        ngot++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (p_mon) begin
        if (cv_txen && p_txen && bus_out != p_bus && !(cv_clk && !p_cv)) viol4++;
        if (cv_rxen && !p_rxen && p_oe) viol8++;
        if (cv_rxen && bus_oe_lo) viol8++;
        if (bus_oe_lo && !p_oe && cv_txen && !p_txen) viol8++;
        if (!ready && (tx_ready || rx_valid)) viol3++;
      end
      if (bus_out == 7'h55) seen_flushed++;
      p_cv = cv_clk; p_txen = cv_txen; p_rxen = cv_rxen; p_oe = bus_oe_lo; p_bus = bus_out;
      p_mon = rst_n;
    end
  end

  task automatic measure_wake(input bit want_tx, output int n);
    int c = 0;
    int t0 = -1;
    n = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      c++;
      if (t0 < 0 && (want_tx ? cv_txen : cv_rxen)) t0 = c;
      if (ready) begin
        n = c - t0;
        break;
      end
    end
  endtask

  task automatic push(input logic [6:0] v);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = v;
    for (int i = 0; i < 100; i++) begin
      if (tx_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cv_txen && !cv_rxen, "R1 reset enables", {cv_txen, cv_rxen}, 0);
    chk(bus_oe_lo && bus_out == 0 && !ready, "R9 reset pins", bus_out, 0);
    chk(!tx_ready && !rx_valid, "R3 reset strobes", tx_ready, 0);
  endtask

  task automatic t_clock(input string tag);
    int c = 0;
    int r = 0;
    int t1 = 0;
    logic pc = cv_clk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      c++;
      if (cv_clk && !pc) begin
        r++;
        if (r == 1) t1 = c;
        if (r == 2) break;
      end
      pc = cv_clk;
    end
    chk(c - t1 == 8, tag, c - t1, 8);
  endtask

  task automatic t_tx;
    int n;
    logic [6:0] vals [0:4];
    vals[0] = 7'h3F; vals[1] = 7'h40; vals[2] = 7'h01; vals[3] = 7'h7F; vals[4] = 7'h2A;
    mode_req = 2'b01;
    measure_wake(1'b1, n);
    chk(n == WAKE, "R3 wake from shutdown", n, WAKE);
    chk(cv_txen && !cv_rxen, "R1 transmit code", {cv_txen, cv_rxen}, 2);
    chk(bus_oe_lo, "R8 drivers on in transmit", bus_oe_lo, 1);
    ngot = 0;
    for (int i = 0; i < 5; i++) push(vals[i]);
    repeat (20) @(negedge clk);
    chk(ngot == 5, "R4 sample count", ngot, 5);
    for (int i = 0; i < 5; i++)
      chk(got[i] == vals[i], "R4 sample order and value", got[i], vals[i]);
    chk(bus_out == 0, "R5 underrun mid-scale", bus_out, 0);
  endtask

  task automatic t_flush;
    logic pc = cv_clk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cv_clk && !pc) break;
      pc = cv_clk;
    end
    tx_valid = 1'b1;
    tx_data = 7'h55;
    @(negedge clk);
    tx_valid = 1'b0;
    mode_req = 2'b10;
  endtask

  task automatic t_rx;
    int n;
    int falls = 0;
    int valids = 0;
    int bad = 0;
    logic pc, pr;
    measure_wake(1'b0, n);
    chk(n == WAKE, "R3 wake on direct change", n, WAKE);
    chk(cv_rxen && !cv_txen, "R1 receive code", {cv_txen, cv_rxen}, 1);
    chk(!bus_oe_lo, "R8 low pins released", bus_oe_lo, 0);
    pc = cv_clk;
    pr = ready;
    for (int i = 0; i < 200 && falls < 10; i++) begin
      @(negedge clk);
      if (pr && !cv_clk && pc) begin
        falls++;
        if (rx_valid) begin
          valids++;
          if (rx_data != bus_in) bad++;
          if (falls == 1) bad++;
        end
      end else if (rx_valid) bad++;
      pc = cv_clk;
      pr = ready;
    end
    chk(valids == 9, "R7 first capture discarded", valids, 9);
    chk(bad == 0, "R6 captured data and timing", bad, 0);
  endtask

  task automatic t_back_tx;
    int n;
    mode_req = 2'b01;
    measure_wake(1'b1, n);
    chk(n == WAKE, "R10 hold-off on receive to transmit", n, WAKE);
    repeat (24) @(negedge clk);
    chk(bus_out == 0, "R10 pending sample flushed", bus_out, 0);
    chk(seen_flushed == 0, "R10 flushed value never driven", seen_flushed, 0);
  endtask

  task automatic t_restart;
    int n;
    mode_req = 2'b10;
    repeat (100) @(negedge clk);
    chk(!ready, "R10 ready dropped on change", ready, 0);
    mode_req = 2'b01;
    measure_wake(1'b1, n);
    chk(n == WAKE, "R10 hold-off restarted", n, WAKE);
  endtask

  task automatic t_shut;
    mode_req = 2'b11;
    repeat (3) @(negedge clk);
    chk(!cv_txen && !cv_rxen, "R1 shutdown code 11", {cv_txen, cv_rxen}, 0);
    chk(bus_oe_lo && bus_out == 0 && !ready, "R9 shutdown pins", bus_out, 0);
    t_clock("R2 clock runs in shutdown");
    mode_req = 2'b00;
    repeat (3) @(negedge clk);
    chk(!cv_txen && !cv_rxen && bus_oe_lo, "R1 shutdown code 00", {cv_txen, cv_rxen}, 0);
  endtask

  initial begin
    t_reset();
    t_clock("R2 clock period");
    t_tx();
    t_flush();
    t_rx();
    t_back_tx();
    t_restart();
    t_shut();
    chk(viol4 == 0, "R4 bus stable outside rising edge", viol4, 0);
    chk(viol8 == 0, "R8 turnaround sequence", viol8, 0);
    chk(viol3 == 0, "R3 no traffic before ready", viol3, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule